// File: doc/BRIEF.md
# Ethernet Destination Address Hash Filter

This block screens the destination address of incoming Ethernet frames against hash tables that software loads. The six address bytes arrive one per accepted beat. The block folds each byte into a running CRC-32 and then uses the top bits of the finished CRC to pick one bit out of sixteen 32-bit hash registers. The frame is a hit when that bit is set. Each set bit stands for a whole family of addresses, so software may still need to drop false positives after a hit.

A single mode input decides how the sixteen registers are used:

- **Normal mode:** the registers form two 256-entry tables, one for unicast frames and one for multicast frames. The table index is 8 CRC bits.
- **Extended mode:** the registers form one 512-entry multicast table. The index is 9 CRC bits, and unicast frames never hit.

The hit and the group flag appear together with a done flag one cycle after the last address byte. All three stay valid until a new address starts.

Top module: `da_hash_filter`

## Requirements
- R1: The CRC register starts at 0xFFFFFFFF. Each address byte is fed in least significant bit first, first byte on the wire first, using generator 0x04C11DB7 in non-reflected shift form. The index is taken from the uncomplemented CRC, starting at bit 31 and moving downward.
- R2: With `ext_mode`=0, the 8-bit index is CRC[31:24]. Unicast frames look it up in registers 0–7 (`cfg_addr` 0–7). Group frames look it up in registers 8–15.
- R3: With `ext_mode`=1, the 9-bit index is CRC[31:23]. Entries 0–255 sit in registers 0–7 and entries 256–511 sit in registers 8–15. The extended table serves group frames only.
- R4: Entry k of a table lives in register k/32 of that table, at bit 31 − (k mod 32). A hit is reported only when that bit is 1.
- R5: `is_group` is bit 0 of the first address byte (1 = group). In extended mode a frame with that bit at 0 never hits.
- R6: Reset clears all sixteen registers, `done` and `hit`. A lookup right after reset therefore misses.
- R7: A start beat is a beat with `addr_valid` and `addr_start` both high. It clears `done` and `hit` at the next edge and begins a new address. `done`, `hit` and `is_group` update at the edge that accepts the sixth byte, and they hold until the next start beat.
- R8: Valid beats without a start are ignored in two cases: after the sixth byte has been taken, and before any start. Outputs do not change.
- R9: The lookup uses the table contents and `ext_mode` as they stand at the edge that accepts the sixth byte. A write landing on that same edge affects only later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Hash register write strobe |
| cfg_addr | input | 4 | Register select: 0–7 first bank, 8–15 second bank |
| cfg_wdata | input | 32 | Write data |
| ext_mode | input | 1 | 0: separate 256-entry tables, 1: 512-entry group table |
| addr_valid | input | 1 | Address byte valid |
| addr_start | input | 1 | Marks the first byte of an address |
| addr_byte | input | 8 | Address byte |
| hit | output | 1 | Indexed entry was set |
| done | output | 1 | Result valid |
| is_group | output | 1 | Group bit of the last address |

## Verification
The assertions assume that `addr_start` is only raised together with `addr_valid`. They also assume that `rst_n` is released far enough from a clock edge that the internal two-flop release has settled before any address starts.

The stimulus follows these rules:
- it drives all inputs on the falling edge;
- it starts every address with exactly one start beat;
- it waits several cycles after reset before sending anything.

Mode changes and register writes are placed between frames or deliberately on the sixth-byte edge. This keeps the sampled-at-sixth-byte rule observable.

// File: rtl/da_hash_pkg.sv
package da_hash_pkg;

  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_GEN  = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

  // Fold one byte into the CRC, least significant bit first.
  function automatic logic [CRC_W-1:0] crc_fold_byte(input logic [CRC_W-1:0] c_in,
                                                     input logic [7:0] din);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[CRC_W-1] ^ din[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_GEN : '0);
    end
    return c;
  endfunction

endpackage

// File: rtl/da_hash_crc.sv
module da_hash_crc
  import da_hash_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_valid,
  input  logic             addr_start,
  input  logic [7:0]       addr_byte,
  output logic [CRC_W-1:0] crc_nx,
  output logic             frame_start,
  output logic             last_accept,
  output logic             grp_nx
);

  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES);

  logic [CRC_W-1:0] crc_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             active_q, active_nx;
  logic             grp_q;
  logic             take_more, accept;

  always_comb begin
    frame_start = addr_valid && addr_start;
    take_more   = addr_valid && !addr_start && active_q;
    accept      = frame_start || take_more;
    crc_nx      = crc_fold_byte(frame_start ? CRC_SEED : crc_q, addr_byte);
    cnt_nx      = frame_start ? CNT_W'(1) : cnt_q + CNT_W'(1);
    last_accept = accept && (cnt_nx == CNT_LAST);
    grp_nx      = frame_start ? addr_byte[0] : grp_q;
    active_nx   = last_accept ? 1'b0 : (frame_start ? 1'b1 : active_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q    <= CRC_SEED;
      cnt_q    <= '0;
      active_q <= 1'b0;
      grp_q    <= 1'b0;
    end else if (accept) begin
      crc_q    <= crc_nx;
      cnt_q    <= cnt_nx;
      active_q <= active_nx;
      grp_q    <= grp_nx;
    end
  end

endmodule

// File: rtl/da_hash_table.sv
module da_hash_table #(
  parameter int unsigned N_REGS = 16,
  parameter int unsigned REG_W  = 32,
  localparam int unsigned RA_W  = $clog2(N_REGS),
  localparam int unsigned BIT_W = $clog2(REG_W),
  localparam int unsigned IDX_W = RA_W - 1 + BIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [RA_W-1:0]  cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             ext_mode,
  input  logic             grp,
  input  logic [IDX_W:0]   key,
  output logic             entry_hit
);

  logic [REG_W-1:0] regs [N_REGS];

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    logic [REG_W-1:0] q;
    logic             wr;
    assign wr = cfg_we && (cfg_addr == RA_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (wr) q <= cfg_wdata;
    end
    assign regs[g] = q;
  end

  logic             bank;
  logic [IDX_W-1:0] low;
  logic [RA_W-1:0]  rsel;
  logic [BIT_W-1:0] bsel;
  logic [REG_W-1:0] row;

  always_comb begin
    bank      = ext_mode ? key[IDX_W] : grp;
    low       = ext_mode ? key[IDX_W-1:0] : key[IDX_W:1];
    rsel      = {bank, low[IDX_W-1:BIT_W]};
    bsel      = BIT_W'(REG_W - 1) - low[BIT_W-1:0];
    row       = regs[rsel];
    entry_hit = row[bsel] && !(ext_mode && !grp);
  end

endmodule

// File: rtl/da_hash_filter.sv
module da_hash_filter
  import da_hash_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned N_REGS     = 16,
  parameter int unsigned REG_W      = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(N_REGS)-1:0] cfg_addr,
  input  logic [REG_W-1:0]          cfg_wdata,
  input  logic                      ext_mode,
  input  logic                      addr_valid,
  input  logic                      addr_start,
  input  logic [7:0]                addr_byte,
  output logic                      hit,
  output logic                      done,
  output logic                      is_group
);

  localparam int unsigned IDX_W = $clog2(N_REGS) - 1 + $clog2(REG_W);

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [CRC_W-1:0] crc_nx;
  logic             frame_start, last_accept, grp_nx, entry_hit;

  da_hash_crc #(.ADDR_BYTES(ADDR_BYTES)) u_crc (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .addr_valid  (addr_valid),
    .addr_start  (addr_start),
    .addr_byte   (addr_byte),
    .crc_nx      (crc_nx),
    .frame_start (frame_start),
    .last_accept (last_accept),
    .grp_nx      (grp_nx)
  );

  logic [CRC_W-1-IDX_W-1:0] crc_unused;
  assign crc_unused = crc_nx[CRC_W-IDX_W-2:0];

  da_hash_table #(.N_REGS(N_REGS), .REG_W(REG_W)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .ext_mode  (ext_mode),
    .grp       (grp_nx),
    .key       (crc_nx[CRC_W-1 -: IDX_W+1]),
    .entry_hit (entry_hit)
  );

  logic hit_d, done_d, grp_d, res_en;

  always_comb begin
    res_en = frame_start || last_accept;
    hit_d  = last_accept && entry_hit;
    done_d = last_accept;
    grp_d  = last_accept ? grp_nx : is_group;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      hit      <= 1'b0;
      done     <= 1'b0;
      is_group <= 1'b0;
    end else if (res_en) begin
      hit      <= hit_d;
      done     <= done_d;
      is_group <= grp_d;
    end
  end

endmodule

// File: rtl/da_hash_filter_chk.sv
module da_hash_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic addr_valid,
  input logic addr_start,
  input logic ext_mode,
  input logic hit,
  input logic done,
  input logic is_group
);

  // R7: a hit is only ever shown with a valid result
  a_r7_hit_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> done);

  // R7: the result is cleared only by a start beat
  a_r7_done_falls_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(addr_valid && addr_start));

  // R8: held result is untouched by beats that are not a start
  a_r8_hold_until_start: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(addr_valid && addr_start)) |=> (done && $stable(hit) && $stable(is_group)));

  // R7: a new result only appears after an accepted byte
  a_r7_rise_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(addr_valid));

  // R5: extended mode never hits an individual address
  a_r5_ext_unicast_miss: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && $past(ext_mode) && !is_group) |-> !hit);

endmodule

bind da_hash_filter da_hash_filter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_valid (addr_valid),
  .addr_start (addr_start),
  .ext_mode   (ext_mode),
  .hit        (hit),
  .done       (done),
  .is_group   (is_group)
);

// File: tb/da_hash_filter_bench.sv
module da_hash_filter_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        ext_mode;
  logic        addr_valid;
  logic        addr_start;
  logic [7:0]  addr_byte;
  logic        hit, done, is_group;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] tb_regs [16];

  always #4 clk = ~clk;

  da_hash_filter u_da_hash_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ext_mode(ext_mode), .addr_valid(addr_valid),
    .addr_start(addr_start), .addr_byte(addr_byte),
    .hit(hit), .done(done), .is_group(is_group)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reflected-form CRC; the index is read back bit-reversed.
  function automatic int ref_idx9(input logic [47:0] da);
    logic [31:0] r;
    logic [7:0]  b;
    int          k;
    r = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      b = da[47-8*i -: 8];
      for (int j = 0; j < 8; j++)
        r = (r[0] ^ b[j]) ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    end
    k = 0;
    for (int j = 0; j < 9; j++) k = k * 2 + int'(r[j]);
    return k;
  endfunction

  function automatic logic exp_hit(input logic [47:0] da, input logic ext);
    int  k9, k8, rg, bt;
    logic grp;
    k9  = ref_idx9(da);
    k8  = k9 / 2;
    grp = da[40];
    if (ext) begin
      if (!grp) return 1'b0;
      rg = k9 / 32; bt = 31 - (k9 % 32);
    end else begin
      rg = (grp ? 8 : 0) + k8 / 32; bt = 31 - (k8 % 32);
    end
    return tb_regs[rg][bt];
  endfunction

  task automatic write_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    tb_regs[a] = d;
  endtask

  // Sends six bytes; optional write placed on the sixth-byte edge.
  task automatic send_da(input logic [47:0] da, input bit wr, input int wa, input logic [31:0] wd);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 1) chk(done == 1'b0 && hit == 1'b0, "R7 cleared by start", {30'd0, done, hit}, 0);
      addr_valid = 1'b1;
      addr_start = (i == 0);
      addr_byte  = da[47-8*i -: 8];
      if (i == 5 && wr) begin
        cfg_we = 1'b1; cfg_addr = 4'(wa); cfg_wdata = wd;
      end
    end
    @(negedge clk);
    addr_valid = 1'b0; addr_start = 1'b0; cfg_we = 1'b0;
    if (wr) tb_regs[wa] = wd;
  endtask

  function automatic logic [47:0] mk_da(input int a);
    logic [7:0] b;
    b = 8'(a);
    return {b, b ^ 8'h5A, 8'(a * 3), 8'(a >> 2), 8'(b + 8'd7), 8'hC3 ^ 8'(a * 11)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] da;
    logic        e, oldv;
    int          k, rg, bt;
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; ext_mode = 0;
    addr_valid = 0; addr_start = 0; addr_byte = 0;
    for (int i = 0; i < 16; i++) tb_regs[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 reset state
    chk(done == 0 && hit == 0, "R6 reset outputs", {30'd0, done, hit}, 0);

    // R8 bytes before any start
    @(negedge clk); addr_valid = 1; addr_byte = 8'hFF;
    repeat (8) @(negedge clk);
    addr_valid = 0;
    chk(done == 0, "R8 no start ignored", {31'd0, done}, 0);

    // R6 cleared tables miss everything
    for (int a = 0; a < 16; a++) begin
      send_da(mk_da(a * 17), 0, 0, 0);
      chk(done && !hit, "R6 zero table miss", {30'd0, done, hit}, 32'h2);
    end

    // R1 R2 R3 R4 R5 sweep: modes x table patterns x addresses
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 16; i++) begin
        if (p == 0)      write_reg(i, 32'hFFFF_FFFF);
        else if (p == 1) write_reg(i, 32'h9E37_79B9 * 32'(i + 1));
        else             write_reg(i, (32'hA5A5_0F0F >> i) ^ 32'(i * 32'h0101_0101));
      end
      for (int m = 0; m < 2; m++) begin
        ext_mode = m[0];
        for (int a = 0; a < 256; a++) begin
          da = mk_da(a);
          e  = exp_hit(da, m[0]);
          send_da(da, 0, 0, 0);
          chk(done && hit == e && is_group == da[40],
              m ? "R3 R5 extended lookup" : "R1 R2 R4 normal lookup",
              {29'd0, done, is_group, hit}, {29'd0, 1'b1, da[40], e});
        end
      end
    end

    // R4 single entry and its neighbour
    ext_mode = 0;
    for (int i = 0; i < 16; i++) write_reg(i, 32'h0);
    da = mk_da(41) | 48'h0100_0000_0000;
    k  = ref_idx9(da) / 2;
    write_reg(8 + k / 32, 32'h1 << (31 - (k % 32)));
    send_da(da, 0, 0, 0);
    chk(hit == 1'b1, "R4 single entry set", {31'd0, hit}, 1);
    write_reg(8 + (k ^ 1) / 32, 32'h1 << (31 - ((k ^ 1) % 32)));
    send_da(da, 0, 0, 0);
    chk(hit == 1'b0, "R4 neighbour entry only", {31'd0, hit}, 0);

    // R8 extra bytes after sixth are ignored and result holds (R7)
    write_reg(8 + k / 32, 32'h1 << (31 - (k % 32)));
    send_da(da, 0, 0, 0);
    @(negedge clk); addr_valid = 1; addr_byte = 8'h00;
    repeat (5) @(negedge clk);
    addr_valid = 0;
    repeat (3) @(negedge clk);
    chk(done && hit && is_group, "R8 R7 result held", {29'd0, done, is_group, hit}, 32'h7);

    // R9 write on sixth-byte edge flips the looked-up bit
    rg = 8 + k / 32; bt = 31 - (k % 32);
    oldv = tb_regs[rg][bt];
    send_da(da, 1, rg, tb_regs[rg] ^ (32'h1 << bt));
    chk(hit == oldv, "R9 write on last edge not used", {31'd0, hit}, {31'd0, oldv});
    send_da(da, 0, 0, 0);
    chk(hit == !oldv, "R9 write used by next lookup", {31'd0, hit}, {31'd0, !oldv});

    // R5 unicast in extended mode with all entries set
    for (int i = 0; i < 16; i++) write_reg(i, 32'hFFFF_FFFF);
    ext_mode = 1;
    send_da(48'h0200_0000_0001, 0, 0, 0);
    chk(done && !hit && !is_group, "R5 ext unicast miss", {29'd0, done, is_group, hit}, 32'h4);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule